// File: doc/BRIEF.md
# Body-Bias LDO Transition Controller

This block sequences a body-bias regulator through an operating-point change. Software programs a settling count and a bias-type choice into a setup register, then writes a control register that names the target operating point and carries a change trigger. If the configuration is coherent, the block drives the matching bias mode to the regulator, holds it through a settling window counted in coarse units of system-clock cycles, and then raises a transition-done flag and an interrupt. The flag is cleared by writing 1 to it.

The register port is a plain single-cycle write strobe with combinational read-back; there is no streaming data path, so no valid/ready handshake or back-pressure applies. Writes are accepted on every clock edge where the strobe is high. Settling units are `CYCLES_PER_UNIT` system-clock cycles long (default 8), and the count field is `CNT_W` bits wide (default 8).

Top module: `abb_ldo_ctrl`

## Requirements
- R1: After reset the bias output is 00, the interrupt is low, and the setup (address 0), control (address 1) and status (address 2) registers all read as zero; address 3 always reads zero.
- R2: With setup holding enable (bit CNT_W) and forward select (bit CNT_W+1) only, a control write with fast select (bit 0) and change (bit 2) drives the bias output to 01 on the next cycle, and status bit 1 (busy) and control bit 2 read 1.
- R3: With setup holding enable and reverse select (bit CNT_W+2) only, a control write with slow select (bit 1) and change drives the bias output to 10 on the next cycle with busy set.
- R4: The done flag sets exactly max(N,1) × CYCLES_PER_UNIT clock edges after the edge that accepts the trigger, where N is the setup count field (bits CNT_W-1:0); a count of zero behaves as one unit.
- R5: On completion status bit 0 (done) reads 1, the interrupt is high for as long as done is set, busy and the control change bit read 0, and the bias output keeps its mode.
- R6: Writing status with bit 0 set clears done and drops the interrupt; writing 0 there leaves it; if completion and a clearing write fall on the same edge, done stays set.
- R7: A trigger is ignored (no busy, no done, bias output unchanged) when enable is clear, when both or neither bias selects are set, when both or neither OPP selects are set, or when the OPP select does not match the bias type (fast needs forward, slow needs reverse).
- R8: While busy, a nonzero control write is ignored entirely: the selects and change bit keep their values, the bias does not change and completion time is unaffected.
- R9: A setup write with enable clear, or a control write of all zeros, returns the block to idle with bias output 00 and no later completion, whether or not a transition is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 setup, 1 control, 2 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| bias_mode | output | 2 | Bias drive to the regulator: 00 off, 01 forward, 10 reverse |
| irq | output | 1 | Interrupt, high while the done flag is set |

## Verification
The properties assume that register writes are single-cycle strobes with stable address and data around the sampling edge, and that only addresses 0 to 2 are written with meaningful fields. The settling-grid property assumes that a transition only starts from idle, so the busy-cycle count it keeps begins at zero for each transition. The bench drives every write on the falling edge for exactly one rising edge, never overlaps a trigger with another write, and chooses settling counts small enough that every window completes well inside the run.

// File: rtl/abb_pkg.sv
`timescale 1ns/1ps
package abb_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_SETUP = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

  // control register bit positions
  localparam int CTL_FAST = 0;
  localparam int CTL_SLOW = 1;
  localparam int CTL_CHG  = 2;

  // status register bit positions
  localparam int STS_DONE = 0;
  localparam int STS_BUSY = 1;

  typedef enum logic [1:0] {
    BIAS_OFF = 2'b00,
    BIAS_FWD = 2'b01,
    BIAS_REV = 2'b10
  } bias_e;
endpackage

// File: rtl/abb_regs.sv
`timescale 1ns/1ps
module abb_regs
  import abb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done_set,
  output logic [CNT_W-1:0]  cfg_cnt,
  output logic              cfg_en,
  output logic              cfg_fwd,
  output logic              cfg_rev,
  output logic              trig,
  output logic              trig_fast,
  output logic              trig_slow,
  output logic              abort,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int EN_BIT  = CNT_W;
  localparam int FWD_BIT = CNT_W + 1;
  localparam int REV_BIT = CNT_W + 2;

  logic setup_wr, ctrl_wr, stat_wr;
  logic ctrl_zero, ctrl_take;
  logic sel_fast_q, sel_slow_q;

  assign setup_wr  = wr && (addr == ADDR_SETUP);
  assign ctrl_wr   = wr && (addr == ADDR_CTRL);
  assign stat_wr   = wr && (addr == ADDR_STAT);
  assign ctrl_zero = (wdata[CTL_CHG:CTL_FAST] == 3'b000);
  assign ctrl_take = ctrl_wr && (!busy || ctrl_zero);

  assign abort     = (setup_wr && !wdata[EN_BIT]) || (ctrl_wr && ctrl_zero);
  assign trig      = ctrl_wr && wdata[CTL_CHG] && !busy;
  assign trig_fast = wdata[CTL_FAST];
  assign trig_slow = wdata[CTL_SLOW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cnt <= '0;
      cfg_en  <= 1'b0;
      cfg_fwd <= 1'b0;
      cfg_rev <= 1'b0;
    end else if (setup_wr) begin
      cfg_cnt <= wdata[CNT_W-1:0];
      cfg_en  <= wdata[EN_BIT];
      cfg_fwd <= wdata[FWD_BIT];
      cfg_rev <= wdata[REV_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_fast_q <= 1'b0;
      sel_slow_q <= 1'b0;
    end else if (ctrl_take) begin
      sel_fast_q <= wdata[CTL_FAST];
      sel_slow_q <= wdata[CTL_SLOW];
    end
  end

  // completion has priority over a clearing write on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          done <= 1'b0;
    else if (done_set)                   done <= 1'b1;
    else if (stat_wr && wdata[STS_DONE]) done <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_SETUP: begin
        rdata[CNT_W-1:0] = cfg_cnt;
        rdata[EN_BIT]    = cfg_en;
        rdata[FWD_BIT]   = cfg_fwd;
        rdata[REV_BIT]   = cfg_rev;
      end
      ADDR_CTRL: begin
        rdata[CTL_FAST] = sel_fast_q;
        rdata[CTL_SLOW] = sel_slow_q;
        rdata[CTL_CHG]  = busy;
      end
      ADDR_STAT: begin
        rdata[STS_DONE] = done;
        rdata[STS_BUSY] = busy;
      end
      default: rdata = '0;
    endcase
  end

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:REV_BIT+1];
endmodule

// File: rtl/abb_seq.sv
`timescale 1ns/1ps
module abb_seq
  import abb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trig,
  input  logic  trig_fast,
  input  logic  trig_slow,
  input  logic  cfg_en,
  input  logic  cfg_fwd,
  input  logic  cfg_rev,
  input  logic  abort,
  input  logic  expire,
  output logic  busy,
  output logic  start,
  output logic  done_set,
  output bias_e bias
);
  logic one_bias, one_opp, match, valid;

  assign one_bias = cfg_fwd ^ cfg_rev;
  assign one_opp  = trig_fast ^ trig_slow;
  assign match    = (trig_fast && cfg_fwd) || (trig_slow && cfg_rev);
  assign valid    = cfg_en && one_bias && one_opp && match;
  assign start    = trig && valid && !abort;
  assign done_set = expire && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      bias <= BIAS_OFF;
    end else if (abort) begin
      busy <= 1'b0;
      bias <= BIAS_OFF;
    end else if (start) begin
      busy <= 1'b1;
      bias <= cfg_fwd ? BIAS_FWD : BIAS_REV;
    end else if (expire) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/abb_timer.sv
`timescale 1ns/1ps
module abb_timer #(
  parameter int CNT_W = 8,
  parameter int UNIT  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             expire
);
  localparam int PRE_W = (UNIT > 1) ? $clog2(UNIT) : 1;

  logic             tick;
  logic [CNT_W-1:0] units_q;

  generate
    if (UNIT == 1) begin : g_direct
      assign tick = run;
    end else begin : g_pre
      localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(UNIT - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (start)  pre_q <= PRE_TOP;
        else if (run)    pre_q <= (pre_q == '0) ? PRE_TOP : pre_q - 1'b1;
      end
      assign tick = run && (pre_q == '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 units_q <= '0;
    else if (start)                             units_q <= load_cnt;
    else if (tick && (units_q > CNT_W'(1)))     units_q <= units_q - 1'b1;
  end

  // a count of 0 or 1 both end on the first unit boundary
  assign expire = tick && (units_q <= CNT_W'(1));
endmodule

// File: rtl/abb_ldo_ctrl.sv
`timescale 1ns/1ps
module abb_ldo_ctrl
  import abb_pkg::*;
#(
  parameter int CNT_W           = 8,
  parameter int CYCLES_PER_UNIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        bias_mode,
  output logic              irq
);
  logic [CNT_W-1:0] cfg_cnt;
  logic cfg_en, cfg_fwd, cfg_rev;
  logic trig, trig_fast, trig_slow, abort;
  logic busy_w, start_w, done_set_w, expire_w, done_w;
  bias_e bias_w;

  abb_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy_w), .done_set(done_set_w),
    .cfg_cnt(cfg_cnt), .cfg_en(cfg_en), .cfg_fwd(cfg_fwd), .cfg_rev(cfg_rev),
    .trig(trig), .trig_fast(trig_fast), .trig_slow(trig_slow), .abort(abort),
    .done(done_w), .rdata(reg_rdata)
  );

  abb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_fast(trig_fast),
    .trig_slow(trig_slow), .cfg_en(cfg_en), .cfg_fwd(cfg_fwd), .cfg_rev(cfg_rev),
    .abort(abort), .expire(expire_w), .busy(busy_w), .start(start_w),
    .done_set(done_set_w), .bias(bias_w)
  );

  abb_timer #(.CNT_W(CNT_W), .UNIT(CYCLES_PER_UNIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_w), .run(busy_w),
    .load_cnt(cfg_cnt), .expire(expire_w)
  );

  assign bias_mode = bias_w;
  assign irq       = done_w;
endmodule

// File: rtl/abb_ldo_ctrl_chk.sv
`timescale 1ns/1ps
module abb_ldo_ctrl_chk #(
  parameter int CNT_W = 8,
  parameter int UNIT  = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic [1:0]  addr,
  input logic [15:0] wdata,
  input logic [1:0]  bias_mode,
  input logic        irq,
  input logic        busy,
  input logic        expire
);
  int unsigned bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  logic unused_w;
  assign unused_w = ^wdata;

  p_bias_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bias_mode != 2'b11);

  p_start_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bias_mode != 2'b00);

  p_unit_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ((bcnt + 1) % UNIT) == 0);

  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd2 && wdata[0] && !expire) |=> !irq);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr) |=> $stable(bias_mode));

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && !wdata[CNT_W]) |=> (bias_mode == 2'b00 && !busy));
endmodule

bind abb_ldo_ctrl abb_ldo_ctrl_chk #(.CNT_W(CNT_W), .UNIT(CYCLES_PER_UNIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
  .bias_mode(bias_mode), .irq(irq), .busy(busy_w), .expire(expire_w)
);

// File: tb/sim_abb_ldo_ctrl.sv
`timescale 1ns/1ps
module sim_abb_ldo_ctrl;
  localparam int U = 8;
  localparam logic [15:0] EN  = 16'h0100;
  localparam logic [15:0] FWD = 16'h0200;
  localparam logic [15:0] REV = 16'h0400;
  localparam logic [15:0] C_FAST = 16'h0001;
  localparam logic [15:0] C_SLOW = 16'h0002;
  localparam logic [15:0] C_CHG  = 16'h0004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [1:0] bias_mode;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  abb_ldo_ctrl #(.CNT_W(8), .CYCLES_PER_UNIT(U)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bias_mode(bias_mode), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start a transition and check completion lands exactly on its edge
  task automatic run_trans(input string req, input logic [15:0] setup,
                           input logic [15:0] ctl, input logic [1:0] exp_bias, input int units);
    logic [15:0] d;
    wr(2'd2, 16'h0001);
    wr(2'd0, setup);
    wr(2'd1, ctl);
    check({req, " bias driven"}, {14'd0, bias_mode}, {14'd0, exp_bias});
    rd(2'd2, d); check({req, " busy"}, d, 16'h0002);
    cycles(units * U - 1);
    check("R4 no early done", {15'd0, irq}, 16'd0);
    cycles(1);
    check("R4 done on time", {15'd0, irq}, 16'd1);
    rd(2'd2, d); check("R5 status done", d, 16'h0001);
    rd(2'd1, d); check("R5 change bit cleared", d & C_CHG, 16'd0);
    check("R5 bias held", {14'd0, bias_mode}, {14'd0, exp_bias});
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 bias", {14'd0, bias_mode}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); check("R1 reg zero", d, 16'd0);
    end
  endtask

  task automatic t_fast;
    run_trans("R2", EN | FWD | 16'd3, C_FAST | C_CHG, 2'b01, 3);
  endtask

  task automatic t_slow;
    run_trans("R3", EN | REV | 16'd5, C_SLOW | C_CHG, 2'b10, 5);
  endtask

  task automatic t_short;
    run_trans("R4 zero count", EN | FWD | 16'd0, C_FAST | C_CHG, 2'b01, 1);
    run_trans("R4 one count", EN | REV | 16'd1, C_SLOW | C_CHG, 2'b10, 1);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    wr(2'd2, 16'h0000);
    check("R6 write 0 keeps done", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'h0001);
    check("R6 write 1 clears", {15'd0, irq}, 16'd0);
    wr(2'd0, EN | FWD | 16'd2);
    wr(2'd1, C_FAST | C_CHG);
    cycles(2 * U - 1);
    wr(2'd2, 16'h0001);   // lands on the completion edge
    check("R6 set wins over clear", {15'd0, irq}, 16'd1);
    rd(2'd2, d); check("R6 status", d, 16'h0001);
    wr(2'd2, 16'h0001);
  endtask

  task automatic invalid_try(input string what, input logic [15:0] setup, input logic [15:0] ctl,
                             input logic [1:0] exp_bias);
    logic [15:0] d;
    wr(2'd0, setup);
    wr(2'd1, ctl);
    rd(2'd2, d); check({"R7 not busy ", what}, d, 16'd0);
    cycles(2 * U);
    check({"R7 no irq ", what}, {15'd0, irq}, 16'd0);
    check({"R7 bias kept ", what}, {14'd0, bias_mode}, {14'd0, exp_bias});
  endtask

  task automatic t_invalid;
    run_trans("R2 prep", EN | FWD | 16'd1, C_FAST | C_CHG, 2'b01, 1);
    wr(2'd2, 16'h0001);
    invalid_try("both bias", EN | FWD | REV | 16'd1, C_FAST | C_CHG, 2'b01);
    invalid_try("mismatch", EN | FWD | 16'd1, C_SLOW | C_CHG, 2'b01);
    invalid_try("no opp", EN | FWD | 16'd1, C_CHG, 2'b01);
    invalid_try("both opp", EN | FWD | 16'd1, C_FAST | C_SLOW | C_CHG, 2'b01);
    invalid_try("no bias", EN | 16'd1, C_FAST | C_CHG, 2'b01);
    invalid_try("enable clear", FWD | 16'd1, C_FAST | C_CHG, 2'b00);
  endtask

  task automatic t_busy;
    logic [15:0] d;
    wr(2'd0, EN | FWD | 16'd4);
    wr(2'd1, C_FAST | C_CHG);
    cycles(9);
    wr(2'd1, C_SLOW | C_CHG);
    rd(2'd1, d); check("R8 ctrl unchanged", d, C_FAST | C_CHG);
    rd(2'd2, d); check("R8 busy reads 1", d, 16'h0002);
    check("R8 bias unchanged", {14'd0, bias_mode}, 16'd1);
    cycles(4 * U - 10 - 1);
    check("R8 no early done", {15'd0, irq}, 16'd0);
    cycles(1);
    check("R8 original timing", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'h0001);
  endtask

  task automatic t_abort;
    logic [15:0] d;
    wr(2'd0, EN | REV | 16'd6);
    wr(2'd1, C_SLOW | C_CHG);
    cycles(5);
    wr(2'd1, 16'h0000);
    check("R9 ctrl zero bias off", {14'd0, bias_mode}, 16'd0);
    rd(2'd2, d); check("R9 ctrl zero idle", d, 16'd0);
    cycles(8 * U);
    check("R9 no done after ctrl abort", {15'd0, irq}, 16'd0);
    wr(2'd0, EN | FWD | 16'd3);
    wr(2'd1, C_FAST | C_CHG);
    cycles(U + 2);
    wr(2'd0, FWD | 16'd3);
    check("R9 setup disable bias off", {14'd0, bias_mode}, 16'd0);
    rd(2'd2, d); check("R9 setup disable idle", d, 16'd0);
    cycles(4 * U);
    check("R9 no done after setup abort", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_fast();
    t_slow();
    t_short();
    t_w1c();
    t_invalid();
    t_busy();
    t_abort();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule